// File: doc/BRIEF.md
# Read-after-write hazard resolver for a five-stage in-order pipeline

This block keeps an in-order pipeline with fetch, decode, execute, memory and writeback stages free of read-after-write errors on register operands. It holds the register indices, write-enable flags and result values of the instructions in the execute, memory and writeback stages. It also holds the register file that the decode stage reads. Each cycle it compares the two source indices of the decode-stage instruction, and of the execute-stage instruction, against the destinations still in flight. From that comparison it either steers a newer value onto the execute operands or asks the front of the pipeline to wait.

A mode input picks the policy. In forwarding mode the execute operands come from the EX/MEM or MEM/WB pipeline register whenever those hold a newer value, and the pipeline never waits. In stall-only mode no value is forwarded. A decode instruction whose source is still being produced is held in place: the program counter and the IF/ID register keep their values, and a no-op is placed into ID/EX. This continues until the producer reaches writeback. The register file completes a write before a read of the same cycle, which shortens every such wait by one cycle.

The surrounding pipeline supplies the decoded fields of the decode-stage instruction and the result computed by its own ALU for the execute-stage instruction. It receives the stall request, the two operand selects and the two resolved operand values.

Top module: `raw_hazard_unit`

## Requirements
- R1: After reset, stall is low, both operand selects are 0 and both execute operands are zero. Every register reads as zero.
- R2: A register written back in a cycle is returned by a decode read of that register in the same cycle.
- R3: In forwarding mode stall never rises. Every execute operand equals the value the source register has in program order.
- R4: Select encoding per operand is 0 = register-file value captured at decode, 1 = EX/MEM result, 2 = MEM/WB result. When both later stages hold the source register, select 1 wins.
- R5: In stall-only mode both selects stay 0. A valid decode instruction stalls while either source equals a write-enabled, non-zero destination held in ID/EX or in EX/MEM.
- R6: In stall-only mode a consumer directly after its producer costs 2 bubble cycles. A consumer with one independent instruction between them costs 1. A consumer three or more slots later costs none.
- R7: While stall is high, the decode instruction is not consumed and ID/EX receives a bubble. The held instruction enters execute the cycle after stall falls.
- R8: Destination register 0 never matches any source. A write to register 0 is discarded, and reading it yields zero.
- R9: A stage whose write-enable is low never causes a forward or a stall, and does not change the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_mode | input | 1 | 1 = forwarding, 0 = stall-only resolution |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs | input | AW (5) | First source index of the decode instruction |
| id_rt | input | AW (5) | Second source index of the decode instruction |
| id_rd | input | AW (5) | Destination index of the decode instruction |
| id_wen | input | 1 | Decode instruction writes its destination |
| ex_result | input | XLEN (32) | ALU result of the instruction now in execute |
| stall | output | 1 | Hold PC and IF/ID, inject a bubble into ID/EX |
| ex_sel_a | output | 2 | Source select of execute operand A |
| ex_sel_b | output | 2 | Source select of execute operand B |
| ex_opnd_a | output | XLEN (32) | Resolved execute operand A |
| ex_opnd_b | output | XLEN (32) | Resolved execute operand B |

## Verification
The stall request depends combinationally on the decode fields in the same cycle. The selects and operand values of an instruction appear in the cycle after the edge that accepted it from decode. Its result lands in the register file three edges after that acceptance, in time for a decode read in the writeback cycle. The bench drives decode fields at the falling edge, waits one time unit and samples stall, selects and operands together. It then advances its own model of the execute, memory and writeback slots by exactly one edge. Bubble counts per dependency distance are totalled over each run and compared with the values stated in R6.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Where an execute operand comes from
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } opnd_src_e;

endpackage

// File: rtl/hz_regfile.sv
module hz_regfile #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);

    logic [NREG-1:0][XLEN-1:0] mem_d, mem_q;

    // Next state: register 0 is never written
    always_comb begin
        mem_d = mem_q;
        if (we && waddr != '0) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Read ports: a same-cycle write is seen first
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (we && waddr == raddr[p]) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = mem_q[raddr[p]];
            end
        end
    end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                    fwd_mode,
    input  logic                    id_valid,
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic                    idex_wen,
    input  logic [AW-1:0]           idex_rd,
    input  logic                    exmem_wen,
    input  logic [AW-1:0]           exmem_rd,
    output logic                    stall
);

    logic [NSRC-1:0] busy;

    // A source is busy while a later writer has not yet reached writeback
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_comb begin
            busy[s] = 1'b0;
            if (idex_wen && idex_rd != '0 && idex_rd == id_src[s]) begin
                busy[s] = 1'b1;
            end
            if (exmem_wen && exmem_rd != '0 && exmem_rd == id_src[s]) begin
                busy[s] = 1'b1;
            end
        end
    end

    assign stall = id_valid && !fwd_mode && (|busy);

endmodule

// File: rtl/hz_fwd_mux.sv
module hz_fwd_mux #(
    parameter int AW   = 5,
    parameter int XLEN = 32
) (
    input  logic                fwd_mode,
    input  logic [AW-1:0]       src,
    input  logic [XLEN-1:0]     reg_val,
    input  logic                exmem_wen,
    input  logic [AW-1:0]       exmem_rd,
    input  logic [XLEN-1:0]     exmem_val,
    input  logic                memwb_wen,
    input  logic [AW-1:0]       memwb_rd,
    input  logic [XLEN-1:0]     memwb_val,
    output hz_pkg::opnd_src_e   sel,
    output logic [XLEN-1:0]     value
);

    import hz_pkg::*;

    // Newest producer wins: EX/MEM is checked before MEM/WB
    always_comb begin
        sel = SRC_REGFILE;
        if (fwd_mode && src != '0) begin
            if (exmem_wen && exmem_rd == src) begin
                sel = SRC_EXMEM;
            end else if (memwb_wen && memwb_rd == src) begin
                sel = SRC_MEMWB;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SRC_EXMEM: value = exmem_val;
            SRC_MEMWB: value = memwb_val;
            default:   value = reg_val;
        endcase
    end

endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fwd_mode,
    input  logic            id_valid,
    input  logic [AW-1:0]   id_rs,
    input  logic [AW-1:0]   id_rt,
    input  logic [AW-1:0]   id_rd,
    input  logic            id_wen,
    input  logic [XLEN-1:0] ex_result,
    output logic            stall,
    output logic [1:0]      ex_sel_a,
    output logic [1:0]      ex_sel_b,
    output logic [XLEN-1:0] ex_opnd_a,
    output logic [XLEN-1:0] ex_opnd_b
);

    import hz_pkg::*;

    localparam int NSRC = 2;

    typedef struct packed {
        logic            vld;
        logic            wen;
        logic [AW-1:0]   rs;
        logic [AW-1:0]   rt;
        logic [AW-1:0]   rd;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } idex_t;

    typedef struct packed {
        logic            wen;
        logic [AW-1:0]   rd;
        logic [XLEN-1:0] data;
    } wb_slot_t;

    typedef struct packed {
        idex_t    idex;
        wb_slot_t exmem;
        wb_slot_t memwb;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NSRC-1:0][AW-1:0]   id_src;
    logic [NSRC-1:0][XLEN-1:0] rf_rdata;
    logic [NSRC-1:0][AW-1:0]   ex_src;
    logic [NSRC-1:0][XLEN-1:0] ex_reg;
    logic [NSRC-1:0][XLEN-1:0] ex_val;
    opnd_src_e [NSRC-1:0]      ex_sel;

    assign id_src = {id_rt, id_rs};
    assign ex_src = {pipe_q.idex.rt, pipe_q.idex.rs};
    assign ex_reg = {pipe_q.idex.b, pipe_q.idex.a};

    hz_regfile #(
        .XLEN (XLEN),
        .NREG (NREG),
        .NRD  (NSRC)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pipe_q.memwb.wen),
        .waddr (pipe_q.memwb.rd),
        .wdata (pipe_q.memwb.data),
        .raddr (id_src),
        .rdata (rf_rdata)
    );

    hz_stall_detect #(
        .AW   (AW),
        .NSRC (NSRC)
    ) u_stall (
        .fwd_mode  (fwd_mode),
        .id_valid  (id_valid),
        .id_src    (id_src),
        .idex_wen  (pipe_q.idex.vld && pipe_q.idex.wen),
        .idex_rd   (pipe_q.idex.rd),
        .exmem_wen (pipe_q.exmem.wen),
        .exmem_rd  (pipe_q.exmem.rd),
        .stall     (stall)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_opnd
        hz_fwd_mux #(
            .AW   (AW),
            .XLEN (XLEN)
        ) u_mux (
            .fwd_mode  (fwd_mode),
            .src       (ex_src[k]),
            .reg_val   (ex_reg[k]),
            .exmem_wen (pipe_q.exmem.wen),
            .exmem_rd  (pipe_q.exmem.rd),
            .exmem_val (pipe_q.exmem.data),
            .memwb_wen (pipe_q.memwb.wen),
            .memwb_rd  (pipe_q.memwb.rd),
            .memwb_val (pipe_q.memwb.data),
            .sel       (ex_sel[k]),
            .value     (ex_val[k])
        );
    end

    assign ex_sel_a  = ex_sel[0];
    assign ex_sel_b  = ex_sel[1];
    assign ex_opnd_a = ex_val[0];
    assign ex_opnd_b = ex_val[1];

    // Next state of all pipeline registers
    always_comb begin
        pipe_d = pipe_q;
        if (stall || !id_valid) begin
            pipe_d.idex = '0;
        end else begin
            pipe_d.idex.vld = 1'b1;
            pipe_d.idex.wen = id_wen;
            pipe_d.idex.rs  = id_rs;
            pipe_d.idex.rt  = id_rt;
            pipe_d.idex.rd  = id_rd;
            pipe_d.idex.a   = rf_rdata[0];
            pipe_d.idex.b   = rf_rdata[1];
        end
        pipe_d.exmem.wen  = pipe_q.idex.vld && pipe_q.idex.wen;
        pipe_d.exmem.rd   = pipe_q.idex.rd;
        pipe_d.exmem.data = ex_result;
        pipe_d.memwb      = pipe_q.exmem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fwd_mode,
    input logic          id_valid,
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic          stall,
    input logic [1:0]    ex_sel_a,
    input logic [1:0]    ex_sel_b,
    input logic          idex_vld,
    input logic [AW-1:0] idex_rs,
    input logic [AW-1:0] idex_rt,
    input logic          exmem_wen,
    input logic [AW-1:0] exmem_rd
);

    a_r3_fwd_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_mode |-> !stall);

    a_r4_sel_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_sel_a != 2'd3) && (ex_sel_b != 2'd3));

    a_r5_stall_mode_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_mode |-> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

    a_r5_exmem_conflict_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_mode && id_valid && exmem_wen && exmem_rd != '0 &&
         (id_rs == exmem_rd || id_rt == exmem_rd)) |-> stall);

    a_r7_bubble_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !idex_vld);

    a_r8_zero_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_sel_a != 2'd0) |-> idex_rs != '0) and ((ex_sel_b != 2'd0) |-> idex_rt != '0));

endmodule

bind raw_hazard_unit hz_checker #(.AW(AW)) u_hz_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_mode  (fwd_mode),
    .id_valid  (id_valid),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .stall     (stall),
    .ex_sel_a  (ex_sel_a),
    .ex_sel_b  (ex_sel_b),
    .idex_vld  (pipe_q.idex.vld),
    .idex_rs   (pipe_q.idex.rs),
    .idex_rt   (pipe_q.idex.rt),
    .exmem_wen (pipe_q.exmem.wen),
    .exmem_rd  (pipe_q.exmem.rd)
);

// File: tb/raw_hazard_unit_bench.sv
module raw_hazard_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = 5;
    localparam int PMAX = 16;

    // bench-side operation codes (the block never sees them)
    localparam int OP_CONST = 0;
    localparam int OP_SUB   = 1;
    localparam int OP_AND   = 2;
    localparam int OP_OR    = 3;
    localparam int OP_ADD   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fwd_mode = 1'b1;
    logic            id_valid = 1'b0;
    logic [AW-1:0]   id_rs = '0;
    logic [AW-1:0]   id_rt = '0;
    logic [AW-1:0]   id_rd = '0;
    logic            id_wen = 1'b0;
    logic [XLEN-1:0] ex_result = '0;
    logic            stall;
    logic [1:0]      ex_sel_a, ex_sel_b;
    logic [XLEN-1:0] ex_opnd_a, ex_opnd_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    raw_hazard_unit #(.XLEN(XLEN), .NREG(NREG)) u_raw_hazard_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_mode  (fwd_mode),
        .id_valid  (id_valid),
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .id_rd     (id_rd),
        .id_wen    (id_wen),
        .ex_result (ex_result),
        .stall     (stall),
        .ex_sel_a  (ex_sel_a),
        .ex_sel_b  (ex_sel_b),
        .ex_opnd_a (ex_opnd_a),
        .ex_opnd_b (ex_opnd_b)
    );

    int checks = 0;
    int errors = 0;

    // program under test
    int          p_op[PMAX], p_rd[PMAX], p_rs[PMAX], p_rt[PMAX], p_wen[PMAX];
    logic [31:0] p_k[PMAX];
    int          p_n = 0;

    // architectural register values in program order
    logic [31:0] gr[NREG];

    // model of the execute, memory and writeback slots
    bit          ex_v = 0, ex_wen = 0;
    int          ex_rs = 0, ex_rt = 0, ex_rd = 0;
    logic [31:0] ex_ea = '0, ex_eb = '0, ex_res = '0;
    bit          m1_v = 0, m1_wen = 0;
    int          m1_rd = 0;
    bit          m2_v = 0, m2_wen = 0;
    int          m2_rd = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int op, input int rd, input int rs, input int rt,
                       input int wen, input logic [31:0] k);
        p_op[p_n] = op; p_rd[p_n] = rd; p_rs[p_n] = rs; p_rt[p_n] = rt;
        p_wen[p_n] = wen; p_k[p_n] = k;
        p_n++;
    endtask

    function automatic logic [1:0] exp_sel(input int src);
        if (!fwd_mode || src == 0) return 2'd0;
        if (m1_v && m1_wen && m1_rd == src) return 2'd1;
        if (m2_v && m2_wen && m2_rd == src) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] alu(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] k);
        case (op)
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_ADD:  return a + b;
            default: return k;
        endcase
    endfunction

    // Run the loaded program; opreq tags the operand checks
    task automatic run(input bit mode, input int exp_bub, input string bubreq,
                       input string opreq, input string name);
        int pc = 0;
        int bub = 0;
        int tail = 0;
        fwd_mode = mode;
        while (tail < 4) begin
            @(negedge clk);
            if (pc < p_n) begin
                id_valid = 1'b1;
                id_rs  = AW'(p_rs[pc]);
                id_rt  = AW'(p_rt[pc]);
                id_rd  = AW'(p_rd[pc]);
                id_wen = p_wen[pc] != 0;
            end else begin
                id_valid = 1'b0;
                id_wen   = 1'b0;
            end
            ex_result = ex_v ? ex_res : '0;
            #1;
            if (ex_v) begin
                chk(opreq, {name, " operand a"}, ex_opnd_a, ex_ea);
                chk(opreq, {name, " operand b"}, ex_opnd_b, ex_eb);
                chk(mode ? "R4" : "R5", {name, " select a"},
                    {30'b0, ex_sel_a}, {30'b0, exp_sel(ex_rs)});
                chk(mode ? "R4" : "R5", {name, " select b"},
                    {30'b0, ex_sel_b}, {30'b0, exp_sel(ex_rt)});
            end
            if (mode || pc >= p_n) begin
                chk(mode ? "R3" : "R7", {name, " stall low"}, {31'b0, stall}, 32'd0);
            end
            // model the edge that follows
            m2_v = m1_v; m2_wen = m1_wen; m2_rd = m1_rd;
            m1_v = ex_v; m1_wen = ex_wen; m1_rd = ex_rd;
            if (pc < p_n && !stall) begin
                ex_v   = 1;
                ex_rs  = p_rs[pc];
                ex_rt  = p_rt[pc];
                ex_rd  = p_rd[pc];
                ex_wen = p_wen[pc] != 0;
                ex_ea  = gr[p_rs[pc]];
                ex_eb  = gr[p_rt[pc]];
                ex_res = alu(p_op[pc], ex_ea, ex_eb, p_k[pc]);
                if (ex_wen && ex_rd != 0) gr[ex_rd] = ex_res;
                pc++;
            end else begin
                ex_v = 0;
                ex_wen = 0;
                if (pc < p_n) bub++;
            end
            if (pc >= p_n) tail++;
        end
        chk(bubreq, {name, " bubble count"}, 32'(bub), 32'(exp_bub));
        p_n = 0;
    endtask

    // dependent chain: one difference read by the next four instructions
    task automatic load_chain();
        put(OP_SUB, 2, 1, 3, 1, '0);
        put(OP_AND, 8, 2, 5, 1, '0);
        put(OP_OR,  9, 6, 2, 1, '0);
        put(OP_ADD, 7, 2, 2, 1, '0);
        put(OP_ADD, 0, 6, 2, 0, '0);   // store-like: reads, writes nothing
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) gr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "stall after reset", {31'b0, stall}, 32'd0);
        chk("R1", "sel a after reset", {30'b0, ex_sel_a}, 32'd0);
        chk("R1", "sel b after reset", {30'b0, ex_sel_b}, 32'd0);
        chk("R1", "opnd a after reset", ex_opnd_a, 32'd0);
        chk("R1", "opnd b after reset", ex_opnd_b, 32'd0);

        // seed registers (sources are register 0, so no stalls)
        put(OP_CONST, 1, 0, 0, 1, 32'd5);
        put(OP_CONST, 3, 0, 0, 1, 32'd12);
        put(OP_CONST, 5, 0, 0, 1, 32'h0000_F0F3);
        put(OP_CONST, 6, 0, 0, 1, 32'h0000_0033);
        run(1'b1, 0, "R8", "R1", "seed");

        // chain, forwarding then stall-only
        load_chain();
        run(1'b1, 0, "R3", "R3", "chain fwd");
        load_chain();
        run(1'b0, 2, "R6", "R2", "chain stall");

        // one independent instruction between producer and consumer
        put(OP_SUB, 10, 1, 3, 1, '0);
        put(OP_ADD, 11, 1, 1, 1, '0);
        put(OP_OR,  12, 10, 6, 1, '0);
        run(1'b1, 0, "R3", "R4", "gap1 fwd");
        put(OP_SUB, 10, 3, 1, 1, '0);
        put(OP_ADD, 11, 1, 1, 1, '0);
        put(OP_OR,  12, 10, 6, 1, '0);
        run(1'b0, 1, "R6", "R2", "gap1 stall");

        // two writers of one register in flight: newest wins
        put(OP_CONST, 4, 0, 0, 1, 32'd7);
        put(OP_CONST, 4, 0, 0, 1, 32'd9);
        put(OP_ADD, 13, 4, 4, 1, '0);
        run(1'b1, 0, "R3", "R4", "priority fwd");
        put(OP_CONST, 4, 0, 0, 1, 32'd21);
        put(OP_CONST, 4, 0, 0, 1, 32'd40);
        put(OP_ADD, 13, 4, 1, 1, '0);
        run(1'b0, 2, "R7", "R7", "priority stall");

        // register 0 as a destination
        put(OP_CONST, 0, 0, 0, 1, 32'd77);
        put(OP_ADD, 14, 0, 0, 1, '0);
        run(1'b1, 0, "R8", "R8", "zero fwd");
        put(OP_CONST, 0, 0, 0, 1, 32'd77);
        put(OP_ADD, 14, 0, 1, 1, '0);
        run(1'b0, 0, "R8", "R8", "zero stall");

        // producer with write-enable low
        put(OP_CONST, 2, 0, 0, 0, 32'd99);
        put(OP_ADD, 15, 2, 1, 1, '0);
        run(1'b1, 0, "R9", "R9", "nowrite fwd");
        put(OP_CONST, 2, 0, 0, 0, 32'd99);
        put(OP_ADD, 15, 2, 1, 1, '0);
        put(OP_OR,  16, 2, 2, 1, '0);
        run(1'b0, 0, "R9", "R9", "nowrite stall");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule